// File: doc/BRIEF.md
# Configuration Access Address Translator

This block sits between a configuration-space access path and a PCI Express root port. Each request names a bus, a device, a function and a register offset. Requests to bus 0 are sent to the root port's own register window. Requests to any other bus are sent through one outbound translation window. The block reprograms that window's translated target and its configuration TLP type for each such request. It then checks the resulting address against the window's enable, base and limit, and emits the translated address.

Requests that name a device which cannot exist on the first two buses are rejected. Rejected writes are dropped and flagged. Rejected reads, reads that miss the window, and completions that come back aborted all return an all-ones data word. Read data from the completer passes through the same return port.

All results leave through one register stage.

Top module: `cfgx_top`

## Requirements
- R1: After reset, acc_valid, acc_local, acc_write, err and rd_valid are 0, acc_addr, acc_wdata and rd_data are 0, win_type is 0x04 and win_target is 0.
- R2: An accepted request on bus 0 or bus 1 sets win_type to 0x04 (type 0 configuration). An accepted request on bus 2 or higher sets it to 0x05 (type 1 configuration).
- R3: An accepted request on a bus other than 0 sets win_target to bus in bits 31:24, device in bits 23:19 and function in bits 18:16, with bits 15:0 at zero. Bus 0 requests leave win_target unchanged.
- R4: Bits 1:0 of the register offset are treated as zero in every generated address.
- R5: A valid bus 0 request gives acc_valid=1 and acc_local=1 one cycle later. In that cycle acc_addr is 0x01FFC000 plus the aligned offset, and acc_write and acc_wdata copy the request.
- R6: A valid request on another bus forms the window address 0x01F00000 plus the aligned offset. If win_enable is 1 and win_base ≤ that address ≤ win_limit, the block gives acc_valid=1 and acc_local=0, with acc_addr = win_target + (address − win_base).
- R7: A request on bus 0 with device above 1, or on bus 1 with device above 0, is rejected. The block gives err=1 and no acc_valid, and leaves win_type and win_target unchanged. A rejected write produces no rd_valid.
- R8: A rejected read, or a valid read that misses the window, gives rd_valid=1 with rd_data 0xFFFFFFFF one cycle later.
- R9: A completion (cpl_valid) gives rd_valid=1 one cycle later. rd_data is cpl_data, or 0xFFFFFFFF when cpl_abort is 1.
- R10: A valid request that misses the window gives err=1 and no acc_valid. It still reprograms win_type and win_target.
- R11: When an all-ones read response and a completion fall in the same cycle, the all-ones response is returned and the completion is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_fn | input | 3 | Target function number |
| req_off | input | 12 | Register byte offset |
| req_wdata | input | 32 | Write data |
| win_enable | input | 1 | Outbound window enable |
| win_base | input | 32 | Outbound window base address |
| win_limit | input | 32 | Outbound window limit address (inclusive) |
| cpl_valid | input | 1 | Completion returned by the port |
| cpl_abort | input | 1 | Completion ended in an abort |
| cpl_data | input | 32 | Completion data |
| acc_valid | output | 1 | Physical access issued |
| acc_local | output | 1 | Access targets the local register window |
| acc_write | output | 1 | Access is a write |
| acc_addr | output | 32 | Physical (local) or translated (downstream) address |
| acc_wdata | output | 32 | Write data of the access |
| err | output | 1 | Request rejected or missed the window |
| rd_valid | output | 1 | Read data returned |
| rd_data | output | 32 | Returned read data |
| win_type | output | 5 | Programmed configuration type code of the window |
| win_target | output | 32 | Programmed translated target of the window |

## Verification
Every result of a request (access, error, all-ones read return and window reprogramming) is due exactly one clock after the request is presented. A completion is returned one clock after it arrives. The bench drives each request just after a falling edge and predicts the outcome with a behavioural model. It compares every output at the next falling edge, which lies after the single register stage, so no stimulus or result is ever sampled at the active edge.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
    localparam int BUS_W  = 8;
    localparam int DEV_W  = 5;
    localparam int FN_W   = 3;
    localparam int OFF_W  = 12;
    localparam int AW     = 32;
    localparam int DW     = 32;
    localparam int TYPE_W = 5;
    localparam int ALIGN_BITS = 2;

    // Configuration TLP type codes used by the outbound window
    typedef enum logic [TYPE_W-1:0] {
        CFG_TYPE0 = 5'h04,
        CFG_TYPE1 = 5'h05
    } cfg_type_e;

    typedef struct packed {
        logic            acc_valid;
        logic            acc_local;
        logic            acc_write;
        logic [AW-1:0]   acc_addr;
        logic [DW-1:0]   acc_wdata;
        logic            err;
        logic            rd_valid;
        logic [DW-1:0]   rd_data;
        cfg_type_e       win_type;
        logic [AW-1:0]   win_target;
    } xlat_state_t;
endpackage

// File: rtl/cfgx_decode.sv
module cfgx_decode
    import cfgx_pkg::*;
#(
    parameter int BUS0_MAX_DEV = 1,
    parameter int BUS1_MAX_DEV = 0,
    parameter int TYPE1_FIRST_BUS = 2
) (
    input  logic [BUS_W-1:0] bus,
    input  logic [DEV_W-1:0] dev,
    input  logic [FN_W-1:0]  fn,
    input  logic [OFF_W-1:0] off,
    output logic             dev_ok,
    output logic             is_local,
    output cfg_type_e        tlp_type,
    output logic [AW-1:0]    target,
    output logic [AW-1:0]    off_al
);
    localparam int TGT_PAD = AW - BUS_W - DEV_W - FN_W;
    localparam logic [DEV_W-1:0] B0_MAX = DEV_W'(BUS0_MAX_DEV);
    localparam logic [DEV_W-1:0] B1_MAX = DEV_W'(BUS1_MAX_DEV);
    localparam logic [BUS_W-1:0] T1_BUS = BUS_W'(TYPE1_FIRST_BUS);

    logic bus_is0;
    logic bus_is1;

    always_comb begin
        bus_is0  = (bus == '0);
        bus_is1  = (bus == BUS_W'(1));
        dev_ok   = !((bus_is0 && (dev > B0_MAX)) || (bus_is1 && (dev > B1_MAX)));
        is_local = bus_is0;
        tlp_type = (bus < T1_BUS) ? CFG_TYPE0 : CFG_TYPE1;
        target   = {bus, dev, fn, {TGT_PAD{1'b0}}};
        off_al   = AW'({off[OFF_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}});
    end
endmodule

// File: rtl/cfgx_window.sv
module cfgx_window
    import cfgx_pkg::*;
#(
    parameter logic [AW-1:0] WIN_ADDR = 32'h01F0_0000
) (
    input  logic            enable,
    input  logic [AW-1:0]   base,
    input  logic [AW-1:0]   limit,
    input  logic [AW-1:0]   target,
    input  logic [AW-1:0]   off_al,
    output logic            hit,
    output logic [AW-1:0]   xlat
);
    logic [AW-1:0] cpu_addr;
    logic          above_base;
    logic          below_limit;

    always_comb begin
        cpu_addr    = WIN_ADDR + off_al;
        above_base  = (cpu_addr >= base);
        below_limit = (cpu_addr <= limit);
        hit         = enable && above_base && below_limit;
        xlat        = target + (cpu_addr - base);
    end
endmodule

// File: rtl/cfgx_top.sv
module cfgx_top
    import cfgx_pkg::*;
#(
    parameter logic [AW-1:0] APER_BASE  = 32'h0100_0000,
    parameter logic [AW-1:0] APER_SIZE  = 32'h0100_0000,
    parameter logic [AW-1:0] WIN_SIZE   = 32'h0010_0000,
    parameter logic [AW-1:0] LOCAL_BASE = 32'h01FF_C000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BUS_W-1:0]  req_bus,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [FN_W-1:0]   req_fn,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [DW-1:0]     req_wdata,
    input  logic              win_enable,
    input  logic [AW-1:0]     win_base,
    input  logic [AW-1:0]     win_limit,
    input  logic              cpl_valid,
    input  logic              cpl_abort,
    input  logic [DW-1:0]     cpl_data,
    output logic              acc_valid,
    output logic              acc_local,
    output logic              acc_write,
    output logic [AW-1:0]     acc_addr,
    output logic [DW-1:0]     acc_wdata,
    output logic              err,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    output logic [TYPE_W-1:0] win_type,
    output logic [AW-1:0]     win_target
);
    localparam logic [AW-1:0] WIN_ADDR = APER_BASE + APER_SIZE - WIN_SIZE;
    localparam logic [DW-1:0] ALL_ONES = '1;

    xlat_state_t st_d, st_q;

    logic          dec_ok;
    logic          dec_local;
    cfg_type_e     dec_type;
    logic [AW-1:0] dec_target;
    logic [AW-1:0] dec_off;
    logic          w_hit;
    logic [AW-1:0] w_xlat;

    cfgx_decode u_dec (
        .bus      (req_bus),
        .dev      (req_dev),
        .fn       (req_fn),
        .off      (req_off),
        .dev_ok   (dec_ok),
        .is_local (dec_local),
        .tlp_type (dec_type),
        .target   (dec_target),
        .off_al   (dec_off)
    );

    // The window is programmed with the new target in the same cycle it is used
    cfgx_window #(.WIN_ADDR(WIN_ADDR)) u_win (
        .enable (win_enable),
        .base   (win_base),
        .limit  (win_limit),
        .target (dec_target),
        .off_al (dec_off),
        .hit    (w_hit),
        .xlat   (w_xlat)
    );

    always_comb begin
        st_d           = st_q;
        st_d.acc_valid = 1'b0;
        st_d.acc_local = 1'b0;
        st_d.acc_write = 1'b0;
        st_d.acc_addr  = '0;
        st_d.acc_wdata = '0;
        st_d.err       = 1'b0;
        st_d.rd_valid  = 1'b0;
        st_d.rd_data   = '0;

        if (cpl_valid) begin
            st_d.rd_valid = 1'b1;
            st_d.rd_data  = cpl_abort ? ALL_ONES : cpl_data;
        end

        if (req_valid) begin
            if (!dec_ok) begin
                st_d.err = 1'b1;
                if (!req_write) begin
                    st_d.rd_valid = 1'b1;
                    st_d.rd_data  = ALL_ONES;
                end
            end else begin
                st_d.win_type = dec_type;
                if (!dec_local) begin
                    st_d.win_target = dec_target;
                end
                if (dec_local) begin
                    st_d.acc_valid = 1'b1;
                    st_d.acc_local = 1'b1;
                    st_d.acc_write = req_write;
                    st_d.acc_addr  = LOCAL_BASE + dec_off;
                    st_d.acc_wdata = req_wdata;
                end else if (w_hit) begin
                    st_d.acc_valid = 1'b1;
                    st_d.acc_write = req_write;
                    st_d.acc_addr  = w_xlat;
                    st_d.acc_wdata = req_wdata;
                end else begin
                    st_d.err = 1'b1;
                    if (!req_write) begin
                        st_d.rd_valid = 1'b1;
                        st_d.rd_data  = ALL_ONES;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q            <= '0;
            st_q.win_type   <= CFG_TYPE0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_valid  = st_q.acc_valid;
    assign acc_local  = st_q.acc_local;
    assign acc_write  = st_q.acc_write;
    assign acc_addr   = st_q.acc_addr;
    assign acc_wdata  = st_q.acc_wdata;
    assign err        = st_q.err;
    assign rd_valid   = st_q.rd_valid;
    assign rd_data    = st_q.rd_data;
    assign win_type   = st_q.win_type;
    assign win_target = st_q.win_target;
endmodule

// File: rtl/cfgx_checker.sv
module cfgx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        cpl_valid,
    input logic        cpl_abort,
    input logic [31:0] cpl_data,
    input logic        acc_valid,
    input logic        acc_local,
    input logic [31:0] acc_addr,
    input logic        err,
    input logic        rd_valid,
    input logic [31:0] rd_data,
    input logic [4:0]  win_type,
    input logic [31:0] win_target
);
    AST_ERR_EXCLUDES_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !acc_valid); // R7
    AST_LOCAL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        acc_local |-> acc_valid); // R5
    AST_LOCAL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        acc_local |-> (acc_addr[1:0] == 2'b00)); // R4
    AST_TYPE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (win_type == 5'h04) || (win_type == 5'h05)); // R2
    AST_TARGET_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        win_target[15:0] == 16'h0); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!acc_valid && !err)); // R6
    AST_CPL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl_abort && !req_valid) |=> (rd_valid && rd_data == $past(cpl_data))); // R9
    AST_CPL_ABORT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_abort) |=> (rd_valid && rd_data == 32'hFFFF_FFFF)); // R9
endmodule

bind cfgx_top cfgx_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .cpl_valid  (cpl_valid),
    .cpl_abort  (cpl_abort),
    .cpl_data   (cpl_data),
    .acc_valid  (acc_valid),
    .acc_local  (acc_local),
    .acc_addr   (acc_addr),
    .err        (err),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .win_type   (win_type),
    .win_target (win_target)
);

// File: tb/sim_cfgx_top.sv
`timescale 1ns/1ps
module sim_cfgx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_fn = '0;
    logic [11:0] req_off = '0;
    logic [31:0] req_wdata = '0;
    logic        win_enable = 1'b0;
    logic [31:0] win_base = '0, win_limit = '0;
    logic        cpl_valid = 1'b0, cpl_abort = 1'b0;
    logic [31:0] cpl_data = '0;
    logic        acc_valid, acc_local, acc_write, err, rd_valid;
    logic [31:0] acc_addr, acc_wdata, rd_data, win_target;
    logic [4:0]  win_type;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // behavioural model state
    logic [4:0]  m_type = 5'h04;
    logic [31:0] m_tgt = '0;
    logic        e_av, e_al, e_aw, e_err, e_rv;
    logic [31:0] e_addr, e_wd, e_rd;

    always #5 clk = ~clk;

    cfgx_top u0 (.*);

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag, input string rtag);
        chk(tag, "acc_valid", 32'(acc_valid), 32'(e_av));
        chk(tag, "acc_local", 32'(acc_local), 32'(e_al));
        chk(tag, "acc_write", 32'(acc_write), 32'(e_aw));
        chk(tag, "acc_addr", acc_addr, e_addr);
        chk(tag, "acc_wdata", acc_wdata, e_wd);
        chk(tag, "err", 32'(err), 32'(e_err));
        chk(rtag, "rd_valid", 32'(rd_valid), 32'(e_rv));
        chk(rtag, "rd_data", rd_data, e_rd);
        chk("R2", "win_type", 32'(win_type), 32'(m_type));
        chk("R3", "win_target", win_target, m_tgt);
    endtask

    // One cycle: drive request/completion, predict, compare after the register stage
    task automatic step(input bit v, input bit w, input int bus, input int dev, input int fn,
                        input int off, input logic [31:0] wd, input bit cv, input bit ca,
                        input logic [31:0] cd, input string tag, input string rtag);
        logic [31:0] al, cpu;
        bit ok;
        req_valid = v; req_write = w; req_bus = 8'(bus); req_dev = 5'(dev);
        req_fn = 3'(fn); req_off = 12'(off); req_wdata = wd;
        cpl_valid = cv; cpl_abort = ca; cpl_data = cd;
        e_av = 0; e_al = 0; e_aw = 0; e_err = 0; e_rv = 0;
        e_addr = 0; e_wd = 0; e_rd = 0;
        if (cv) begin
            e_rv = 1; e_rd = ca ? 32'hFFFF_FFFF : cd;
        end
        if (v) begin
            ok = !((bus == 0 && dev > 1) || (bus == 1 && dev > 0));
            al = 32'(off) & ~32'h3;
            if (!ok) begin
                e_err = 1;
                if (!w) begin e_rv = 1; e_rd = 32'hFFFF_FFFF; end
            end else begin
                m_type = (bus < 2) ? 5'h04 : 5'h05;
                if (bus != 0) m_tgt = (32'(bus) << 24) | (32'(dev) << 19) | (32'(fn) << 16);
                if (bus == 0) begin
                    e_av = 1; e_al = 1; e_aw = w; e_wd = wd;
                    e_addr = 32'h01FF_C000 + al;
                end else begin
                    cpu = 32'h01F0_0000 + al;
                    if (win_enable && cpu >= win_base && cpu <= win_limit) begin
                        e_av = 1; e_aw = w; e_wd = wd;
                        e_addr = m_tgt + (cpu - win_base);
                    end else begin
                        e_err = 1;
                        if (!w) begin e_rv = 1; e_rd = 32'hFFFF_FFFF; end
                    end
                end
            end
        end
        @(negedge clk);
        compare(tag, rtag);
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6", "R9");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        e_av = 0; e_al = 0; e_aw = 0; e_err = 0; e_rv = 0; e_addr = 0; e_wd = 0; e_rd = 0;
        compare("R1", "R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1", "R1");

        win_enable = 1; win_base = 32'h01F0_0000; win_limit = 32'h01FF_FFFF;
        // local window, offset alignment R4/R5
        step(1, 0, 0, 0, 0, 'h013, 0, 0, 0, 0, "R4", "R8");
        step(1, 1, 0, 1, 2, 'h7FE, 32'hCAFE_0001, 0, 0, 0, "R5", "R8");
        // rejected on bus 0, read and write R7/R8
        step(1, 0, 0, 2, 0, 'h010, 0, 0, 0, 0, "R7", "R8");
        step(1, 1, 0, 31, 0, 'h010, 32'h1234, 0, 0, 0, "R7", "R7");
        // downstream type 0 R6/R2/R3
        step(1, 0, 1, 0, 3, 'h105, 0, 0, 0, 0, "R6", "R8");
        step(1, 1, 1, 1, 0, 'h000, 32'h5, 0, 0, 0, "R7", "R7");
        step(1, 1, 2, 5, 7, 'h040, 32'hA5A5_5A5A, 0, 0, 0, "R6", "R8");
        step(1, 0, 255, 31, 7, 'hFFF, 0, 0, 0, 0, "R6", "R8");
        step(1, 0, 0, 0, 0, 'h004, 0, 0, 0, 0, "R3", "R8");
        idle();
        // window disabled R10
        win_enable = 0;
        step(1, 0, 3, 4, 1, 'h020, 0, 0, 0, 0, "R10", "R8");
        step(1, 1, 3, 4, 1, 'h020, 32'h77, 0, 0, 0, "R10", "R8");
        win_enable = 1;
        // base above the window address R10
        win_base = 32'h01F0_0100;
        step(1, 0, 4, 0, 0, 'h0FC, 0, 0, 0, 0, "R10", "R8");
        step(1, 0, 4, 0, 0, 'h100, 0, 0, 0, 0, "R6", "R8");
        // limit boundary R6/R10
        win_base = 32'h01F0_0000; win_limit = 32'h01F0_0200;
        step(1, 0, 5, 2, 2, 'h200, 0, 0, 0, 0, "R6", "R8");
        step(1, 0, 5, 2, 2, 'h204, 0, 0, 0, 0, "R10", "R8");
        win_limit = 32'h01FF_FFFF;
        // completions R9
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, 32'hDEAD_BEEF, "R6", "R9");
        step(0, 0, 0, 0, 0, 0, 0, 1, 1, 32'h0000_1111, "R6", "R9");
        step(1, 1, 1, 0, 0, 'h008, 32'h9, 1, 0, 32'h0BAD_F00D, "R6", "R9");
        // coincident all-ones response wins R11
        step(1, 0, 1, 3, 0, 'h008, 0, 1, 0, 32'h0123_4567, "R7", "R11");
        win_enable = 0;
        step(1, 0, 6, 0, 0, 'h008, 0, 1, 0, 32'h0123_4567, "R10", "R11");
        win_enable = 1;
        idle();
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            int b;
            b = ($urandom % 4 == 0) ? 0 : int'($urandom % 6);
            step(($urandom % 4) != 0, $urandom % 2, b, int'($urandom % 32) % ((b < 2) ? 3 : 32),
                 int'($urandom % 8), int'($urandom % 4096), $urandom,
                 ($urandom % 3) == 0, ($urandom % 4) == 0, $urandom, "R6", "R9");
        end
        idle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule